// File: doc/BRIEF.md
# Bit-Serial Montgomery Modular Multiplier

This block computes the Montgomery product x·y·2^-N mod m for an odd modulus m of at most N bits. It is the inner engine of a modular exponentiation datapath. A controller places the two operands and the modulus on the input pins and pulses `start`. The block then works for a fixed number of cycles and presents a fully reduced N-bit result, with `done` raised.

The multiplier is radix-2 and bit-serial. It takes one bit of x per cycle, starting from the least significant bit. In each cycle it adds y when that bit is set. It then adds m when the running sum would otherwise be odd, which needs only the sum's low bit because m is odd. Finally it halves the sum. The running sum is kept as a sum word and a carry word, so the loop carries no long carry chain. After the loop, one cycle folds the two words into one binary value. A last cycle subtracts m once if the folded value is not below m.

Top module: `mont_mul`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: For an odd m and operands 0 ≤ x, y < m, the final `result` is the unique value r with r < m and r·2^N ≡ x·y (mod m).
- R3: `busy` is 1 from the clock edge that samples `start` until the edge N+2 cycles later. At that later edge `busy` falls and `done` rises. `busy` and `done` are never 1 at the same time.
- R4: The operand values `x_in`, `y_in` and `m_in` are captured only at the edge that accepts `start`. Changing them while `busy` is 1 does not alter the result.
- R5: A `start` pulse while `busy` is 1 is ignored. It neither restarts the operation nor changes its completion cycle or its result.
- R6: After completion, `done` stays 1 and `result` keeps its value until the next accepted `start`. That `start` clears `done` at the same edge that raises `busy`.
- R7: Boundary operands give exact results: x = 0 gives 0, and x = y = m−1 gives the congruent value below m.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when the block is idle |
| x_in | input | N | Multiplier operand, consumed one bit per cycle, LSB first |
| y_in | input | N | Multiplicand operand |
| m_in | input | N | Odd modulus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid; held until the next accepted start |
| result | output | N | Montgomery product, fully reduced below m |

## Verification
The bench builds two copies of the block, one with N = 32 and one with N = 64. These widths keep each run under seventy cycles, so random odd moduli, the all-ones modulus, x = 0 and x = y = m−1 can all be covered, and a start pulse can be injected partway through a run. The 64-bit copy pushes the carry-save words and the final subtraction past a machine word. The expected result is not computed by a second Montgomery loop. Instead, the bench checks the congruence r·2^N ≡ x·y mod m with wide integers, and checks that r < m.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOP,
    ST_FOLD,
    ST_TRIM
  } mont_state_e;
endpackage

// File: rtl/mont_csa_step.sv
// One radix-2 iteration on a carry-save accumulator:
// (sum + carry + xbit*y + q*m) / 2, with q chosen so the total is even.
module mont_csa_step #(
  parameter int N = 1024
) (
  input  logic [N+1:0] sum_i,
  input  logic [N+1:0] carry_i,
  input  logic [N-1:0] y_i,
  input  logic [N-1:0] m_i,
  input  logic         xbit_i,
  output logic [N+1:0] sum_o,
  output logic [N+1:0] carry_o
);
  localparam int W = N + 2;

  logic [W-1:0] py, pm, s1, c1, s2, c2;
  logic         q;

  always_comb begin
    py = xbit_i ? {2'b00, y_i} : '0;
    q  = sum_i[0] ^ carry_i[0] ^ py[0];
    pm = q ? {2'b00, m_i} : '0;
    s1 = sum_i ^ carry_i ^ py;
    c1 = ((sum_i & carry_i) | (sum_i & py) | (carry_i & py)) << 1;
    s2 = s1 ^ c1 ^ pm;
    c2 = ((s1 & c1) | (s1 & pm) | (c1 & pm)) << 1;
    sum_o   = s2 >> 1;
    carry_o = c2 >> 1;
  end
endmodule

// File: rtl/mont_final_sub.sv
// Single conditional subtraction: brings a value below 2m under m.
module mont_final_sub #(
  parameter int N = 1024
) (
  input  logic [N:0]   acc_i,
  input  logic [N-1:0] m_i,
  output logic [N-1:0] res_o
);
  localparam int W = N + 2;

  logic [W-1:0] diff;
  logic         ge;

  always_comb begin
    diff  = {1'b0, acc_i} - {2'b00, m_i};
    ge    = ~diff[W-1];
    res_o = ge ? diff[N-1:0] : acc_i[N-1:0];
  end
endmodule

// File: rtl/mont_mul.sv
module mont_mul #(
  parameter int N = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic [N-1:0] m_in,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);
  import mont_pkg::*;

  localparam int W  = N + 2;
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST_ITER = CW'(N - 1);

  mont_state_e   state;
  logic [N-1:0]  x_q, y_q, m_q;
  logic [W-1:0]  acc_s, acc_c, nxt_s, nxt_c, folded;
  logic [N:0]    acc_f;
  logic [CW-1:0] iter;
  logic [N-1:0]  trimmed;

  mont_csa_step #(.N(N)) u_step (
    .sum_i   (acc_s),
    .carry_i (acc_c),
    .y_i     (y_q),
    .m_i     (m_q),
    .xbit_i  (x_q[0]),
    .sum_o   (nxt_s),
    .carry_o (nxt_c)
  );

  mont_final_sub #(.N(N)) u_sub (
    .acc_i (acc_f),
    .m_i   (m_q),
    .res_o (trimmed)
  );

  assign folded = acc_s + acc_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      x_q    <= '0;
      y_q    <= '0;
      m_q    <= '0;
      acc_s  <= '0;
      acc_c  <= '0;
      acc_f  <= '0;
      iter   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            x_q   <= x_in;
            y_q   <= y_in;
            m_q   <= m_in;
            acc_s <= '0;
            acc_c <= '0;
            iter  <= LAST_ITER;
            busy  <= 1'b1;
            done  <= 1'b0;
            state <= ST_LOOP;
          end
        end
        ST_LOOP: begin
          acc_s <= nxt_s;
          acc_c <= nxt_c;
          x_q   <= x_q >> 1;
          if (iter == '0) state <= ST_FOLD;
          else            iter  <= iter - 1'b1;
        end
        ST_FOLD: begin
          acc_f <= folded[N:0];
          state <= ST_TRIM;
        end
        ST_TRIM: begin
          result <= trimmed;
          done   <= 1'b1;
          busy   <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
  parameter int N = 1024
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] result,
  input logic [N-1:0] m_q
);
  int unsigned cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= 0;
    else if (start && !busy) cnt <= 1;
    else if (busy)          cnt <= cnt + 1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && result == '0));

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> cnt == N + 3);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(result)));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (!done && busy));

  // R2
  below_mod_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> result < m_q);
endmodule

bind mont_mul mont_mul_chk #(.N(N)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result),
  .m_q    (m_q)
);

// File: tb/mont_mul_test.sv
module mont_mul_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        st32 = 0, st64 = 0;
  logic [31:0] x32 = 0, y32 = 0, m32 = 1, r32;
  logic [63:0] x64 = 0, y64 = 0, m64 = 1, r64;
  logic        b32, d32, b64, d64;

  int checks = 0, errors = 0;
  bit finished = 0;

  mont_mul #(.N(32)) uut (
    .clk(clk), .rst(rst), .start(st32), .x_in(x32), .y_in(y32), .m_in(m32),
    .busy(b32), .done(d32), .result(r32));

  mont_mul #(.N(64)) uut_w (
    .clk(clk), .rst(rst), .start(st64), .x_in(x64), .y_in(y64), .m_in(m64),
    .busy(b64), .done(d64), .result(r64));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ctl(input int w);
    return (w == 32) ? {b32, d32} : {b64, d64};
  endfunction

  function automatic logic [63:0] res_of(input int w);
    return (w == 32) ? {32'b0, r32} : r64;
  endfunction

  task automatic drive(input int w, input logic [63:0] x, y, m, input logic s);
    if (w == 32) begin x32 = x[31:0]; y32 = y[31:0]; m32 = m[31:0]; st32 = s; end
    else         begin x64 = x;       y64 = y;       m64 = m;       st64 = s; end
  endtask

  task automatic set_start(input int w, input logic s);
    if (w == 32) st32 = s; else st64 = s;
  endtask

  // R2: r < m and r*2^w == x*y (mod m)
  function automatic bit congruent(input int w, input logic [63:0] r, x, y, m);
    logic [255:0] rr, xx, yy, mm;
    rr = {192'b0, r}; xx = {192'b0, x}; yy = {192'b0, y}; mm = {192'b0, m};
    return (rr < mm) && (((rr << w) % mm) == ((xx * yy) % mm));
  endfunction

  task automatic run(input int w, input logic [63:0] x, y, m, input bit poke,
                     input string req);
    logic [63:0] r;
    @(negedge clk);
    drive(w, x, y, m, 1'b1);
    for (int j = 0; j <= w + 1; j++) begin
      @(negedge clk);
      set_start(w, 1'b0);
      if (poke && j == 2) begin
        // R4, R5: scramble operands and pulse start while busy
        drive(w, ~x, ~y, m ^ 64'h2, 1'b1);
      end
      check(ctl(w) == 2'b10, "R3 busy window", {62'b0, ctl(w)}, 64'h2);
    end
    @(negedge clk);
    check(ctl(w) == 2'b01, "R3 done edge", {62'b0, ctl(w)}, 64'h1);
    r = res_of(w);
    check(congruent(w, r, x, y, m), req, r, m);
    repeat (3) @(negedge clk);
    check(ctl(w) == 2'b01 && res_of(w) == r, "R6 hold", res_of(w), r);
  endtask

  function automatic logic [63:0] rnd_mod(input int w);
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (w == 32) v = {32'b0, v[31:0]};
    return v | 64'h1;
  endfunction

  task automatic rnd_run(input int w, input bit poke, input string req);
    logic [63:0] m, x, y;
    m = rnd_mod(w);
    x = {$urandom, $urandom} % m;
    y = {$urandom, $urandom} % m;
    run(w, x, y, m, poke, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(b32 == 0 && d32 == 0 && r32 == 0, "R1 reset n32", {r32, 30'b0, b32, d32}, 0);
    check(b64 == 0 && d64 == 0 && r64 == 0, "R1 reset n64", r64 | {b64, d64}, 0);
    rst = 0;
    run(32, 0, 64'h1234, 64'hFFFF_FFFB, 0, "R7 x zero");
    run(32, 64'hFFFF_FFFA, 64'hFFFF_FFFA, 64'hFFFF_FFFB, 0, "R7 m-1 squared");
    run(32, 1, 1, 64'hFFFF_FFFF, 0, "R2 one by one");
    run(64, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE,
        64'hFFFF_FFFF_FFFF_FFFF, 0, "R7 m-1 squared n64");
    run(64, 0, 64'h55, 64'h8000_0000_0000_0001, 0, "R7 x zero n64");
    run(32, 64'h0BAD_F00D, 64'h1234_5678, 64'hC000_0001, 1, "R4 R5 ignored n32");
    run(64, 64'h0123_4567_89AB_CDEF, 64'h0FED_CBA9_8765_4321,
        64'hF000_0000_0000_0011, 1, "R4 R5 ignored n64");
    for (int i = 0; i < 20; i++) rnd_run(32, 0, "R2 random n32");
    for (int i = 0; i < 20; i++) rnd_run(64, i % 5 == 0, "R2 random n64");
    // R6: start at done clears done and raises busy
    @(negedge clk); st32 = 1;
    @(negedge clk); st32 = 0;
    check(b32 == 1 && d32 == 0, "R6 restart", {62'b0, b32, d32}, 64'h2);
    repeat (40) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule